// File: doc/BRIEF.md
# Transmit Completion Queue with Interrupt Status

This block keeps the transmit-completion side of a packet network controller. Each packet number whose transmission finishes is appended to a small in-order completion queue, unless automatic buffer release is on. In that case the number is handed straight back as a release request. Software sees the oldest completed number at a head port. It drains the queue by acknowledging the transmit interrupt, and each acknowledge removes one entry.

A latched status byte collects interrupt causes. The transmit bit stays forced on while completions remain queued. The transmit-empty bit is forced on while no transmit is pending. A mask byte gates the status onto a single level interrupt line.

Register writes use one byte-wide port with a two-bit select: 0 is acknowledge, 1 is the mask, and 2 is a memory-unit command. The command code sits in write-data bits 7:5. Command 2 resets the whole memory unit and command 7 resets the transmit queues. The block keeps a count of pending transmits. It also emits the receive-queue and allocation clear strobes for the neighbouring logic.

Top module: `tx_cmpl_irq`

## Requirements
- R1: With automatic release off, each completion event appends its packet number to the queue, and the numbers leave in the order they arrived.
- R2: A completion arriving while the queue holds DEPTH entries (4 by default), with no pop in the same cycle, is discarded and the queue is unchanged.
- R3: With automatic release on, a completion is not queued; `rel_req` and `rel_pkt` present that packet number in the same cycle.
- R4: `cq_head` reads 8'h80 when the queue is empty and the zero-extended oldest entry otherwise. Looking at it removes nothing.
- R5: An acknowledge write (select 0) clears the status bits set in both the data and 8'hD6. Bits 0, 3 and 5 are never cleared by it.
- R6: An acknowledge write with data bit 1 set pops one entry. On an empty queue it changes nothing.
- R7: Status bit 1 (transmit) is 1 after every cycle that leaves the queue non-empty. External cause bits from `st_set` are ORed into the status before the acknowledge is applied.
- R8: Status bit 2 (transmit-empty) is 1 after every cycle that leaves the pending-transmit count at zero. While transmits are pending, an acknowledge can clear it.
- R9: `irq` is high exactly when status AND mask is nonzero. The mask is written with select 1 and takes effect on the next cycle.
- R10: Command 2 (select 2, data[7:5]=2) empties the pending count and the completion queue and pulses `rx_clr` and `alloc_clr` in the same cycle. Command 7 empties only the pending count and the completion queue. Other codes change nothing.
- R11: After reset the queue and pending count are empty, status is 8'h04, the mask is 0 and `irq` is low.
- R12: When a pop and a completion coincide, the pop removes the old head first and then the new number is appended, so a full queue accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_vld | input | 1 | A packet finished transmitting |
| done_pkt | input | PW | Number of the finished packet |
| auto_rel | input | 1 | Automatic buffer release enable |
| tx_enq | input | 1 | A packet was queued for transmission |
| st_set | input | 8 | External status causes to latch |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 acknowledge, 1 mask, 2 command |
| wr_data | input | 8 | Write data |
| cq_head | output | 8 | Oldest completion, or 8'h80 when empty |
| status | output | 8 | Latched status byte |
| irq | output | 1 | Level interrupt |
| rel_req | output | 1 | Buffer release request |
| rel_pkt | output | PW | Packet number to release |
| rx_clr | output | 1 | Receive-queue clear strobe |
| alloc_clr | output | 1 | Allocation state clear strobe |

## Verification
Directed sequences fill the queue past its depth and then drain it. They distinguish in-order delivery from a dropped or reordered entry, and show when an overflowing push is lost. A pop that coincides with a push on a full queue tells pop-then-append ordering apart from the reverse. Writing all ones to acknowledge separates the acknowledgeable bits from the sticky ones. Seeded random mixes of completions, release mode, commands, masks and cause bits are compared each cycle with a bench model, which exposes wrong forcing of the transmit bits and wrong clear scope of the commands.

// File: rtl/tx_cmpl_irq.sv
module tx_cmpl_irq #(
  parameter int DEPTH = 4,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_vld,
  input  logic [PW-1:0] done_pkt,
  input  logic          auto_rel,
  input  logic          tx_enq,
  input  logic [7:0]    st_set,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [7:0]    wr_data,
  output logic [7:0]    cq_head,
  output logic [7:0]    status,
  output logic          irq,
  output logic          rel_req,
  output logic [PW-1:0] rel_pkt,
  output logic          rx_clr,
  output logic          alloc_clr
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [7:0] ACK_OK = 8'hD6;
  localparam logic [7:0] EMPTY_MARK = 8'h80;

  logic [PW-1:0] q [DEPTH];
  logic [PW-1:0] q_n [DEPTH];
  logic [CW-1:0] cnt, cnt_n, pend, pend_n;
  logic [7:0]    mask, st_n;

  wire [2:0] cmd   = wr_data[7:5];
  wire is_ack      = wr_en && wr_sel == 2'd0;
  wire is_cmd      = wr_en && wr_sel == 2'd2;
  wire pop         = is_ack && wr_data[1];
  wire push        = done_vld && !auto_rel;
  wire mmu_rst     = is_cmd && cmd == 3'd2;
  wire txq_clr     = mmu_rst || (is_cmd && cmd == 3'd7);

  assign rel_req   = done_vld && auto_rel;
  assign rel_pkt   = done_pkt;
  assign rx_clr    = mmu_rst;
  assign alloc_clr = mmu_rst;
  assign cq_head   = (cnt == '0) ? EMPTY_MARK : {{(8-PW){1'b0}}, q[0]};
  assign irq       = |(status & mask);

  always_comb begin
    cnt_n = cnt;
    for (int i = 0; i < DEPTH; i++) q_n[i] = q[i];
    if (pop && cnt != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) q_n[i] = q[i+1];
      cnt_n = cnt - 1'b1;
    end
    if (push && cnt_n < FULL) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == cnt_n) q_n[i] = done_pkt;
      cnt_n = cnt_n + 1'b1;
    end
    if (txq_clr) cnt_n = '0;
  end

  always_comb begin
    pend_n = pend;
    if (tx_enq && !(done_vld && pend != '0) && pend < FULL) pend_n = pend + 1'b1;
    else if (!tx_enq && done_vld && pend != '0)           pend_n = pend - 1'b1;
    if (txq_clr) pend_n = '0;
  end

  always_comb begin
    st_n = status | st_set;
    if (is_ack) st_n = st_n & ~(wr_data & ACK_OK);
    if (cnt_n != '0) st_n[1] = 1'b1;
    if (pend_n == '0) st_n[2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      pend   <= '0;
      status <= 8'h04;
      mask   <= '0;
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else begin
      cnt    <= cnt_n;
      pend   <= pend_n;
      status <= st_n;
      if (wr_en && wr_sel == 2'd1) mask <= wr_data;
      for (int i = 0; i < DEPTH; i++) q[i] <= q_n[i];
    end
  end

  p_push_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !txq_clr && cnt < FULL) |=> cnt == $past(cnt) + 1'b1);
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !txq_clr && cnt == FULL) |=> (cnt == FULL && $stable(cq_head)));
  p_rel_noq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_req && !pop && !txq_clr) |=> $stable(cnt));
  p_head_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !pop && !txq_clr) |=> $stable(cq_head));
  p_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !txq_clr && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  p_txbit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> status[1]);
  p_txempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> status[2]);
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    txq_clr |=> (cnt == '0 && cq_head == EMPTY_MARK));
endmodule

// File: tb/sim_tx_cmpl_irq.sv
`timescale 1ns/1ps
module sim_tx_cmpl_irq;
  localparam int D = 4;
  logic clk = 0, rst_n = 0;
  logic done_vld = 0, auto_rel = 0, tx_enq = 0, wr_en = 0;
  logic [5:0] done_pkt = 0;
  logic [7:0] st_set = 0, wr_data = 0;
  logic [1:0] wr_sel = 0;
  logic [7:0] cq_head, status;
  logic irq, rel_req, rx_clr, alloc_clr;
  logic [5:0] rel_pkt;
  int nchk = 0, nerr = 0;
  int mq [D];
  int mcnt = 0, mpend = 0;
  logic [7:0] mst = 8'h04, mmask = 0;

  always #2.5 clk = ~clk;

  tx_cmpl_irq u0 (.clk(clk), .rst_n(rst_n), .done_vld(done_vld), .done_pkt(done_pkt),
    .auto_rel(auto_rel), .tx_enq(tx_enq), .st_set(st_set), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cq_head(cq_head), .status(status), .irq(irq), .rel_req(rel_req),
    .rel_pkt(rel_pkt), .rx_clr(rx_clr), .alloc_clr(alloc_clr));

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_head();
    return (mcnt == 0) ? 8'h80 : mq[0];
  endfunction

  task automatic outs(string tag);
    chk({tag, " head"}, cq_head, exp_head());
    chk({tag, " status"}, status, mst);
    chk({tag, " irq R9"}, irq, |(mst & mmask));
  endtask

  task automatic step(bit we, bit [1:0] a, bit [7:0] d, bit v, bit ar, bit [5:0] pk,
                      bit enq, bit [7:0] ev, string tag);
    bit pop, push, clr, mmu;
    wr_en = we; wr_sel = a; wr_data = d; done_vld = v; auto_rel = ar;
    done_pkt = pk; tx_enq = enq; st_set = ev;
    pop = we && a == 0 && d[1];
    push = v && !ar;
    mmu = we && a == 2 && d[7:5] == 2;
    clr = mmu || (we && a == 2 && d[7:5] == 7);
    #1;
    chk({tag, " rel_req R3"}, rel_req, v && ar);
    if (v && ar) chk({tag, " rel_pkt R3"}, rel_pkt, pk);
    chk({tag, " rx_clr R10"}, rx_clr, mmu);
    chk({tag, " alloc_clr R10"}, alloc_clr, mmu);
    if (pop && mcnt > 0) begin
      for (int i = 0; i < D - 1; i++) mq[i] = mq[i+1];
      mcnt--;
    end
    if (push && mcnt < D) begin mq[mcnt] = pk; mcnt++; end
    if (clr) mcnt = 0;
    if (enq && !(v && mpend > 0) && mpend < D) mpend++;
    else if (!enq && v && mpend > 0) mpend--;
    if (clr) mpend = 0;
    mst = mst | ev;
    if (we && a == 0) mst = mst & ~(d & 8'hD6);
    if (mcnt != 0) mst[1] = 1;
    if (mpend == 0) mst[2] = 1;
    if (we && a == 1) mmask = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; done_vld = 0; tx_enq = 0; st_set = 0;
    outs(tag);
  endtask

  task automatic idle(string tag); step(0, 0, 0, 0, 0, 0, 0, 0, tag); endtask
  task automatic done(bit [5:0] pk, string tag); step(0, 0, 0, 1, 0, pk, 0, 0, tag); endtask
  task automatic ack(bit [7:0] d, string tag); step(1, 0, d, 0, 0, 0, 0, 0, tag); endtask

  initial begin
    #100000;
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    outs("R11 reset");
    for (int i = 1; i <= 4; i++) done(6'(i), "R1 fill");
    done(6'd5, "R2 drop when full");
    chk("R2 head after drop", cq_head, 1);
    ack(8'h02, "R6 pop");
    chk("R1 order", cq_head, 2);
    done(6'd9, "R1 refill");
    step(1, 0, 8'h02, 1, 0, 6'd10, 0, 0, "R12 pop+push full");
    chk("R12 head", cq_head, 3);
    for (int i = 0; i < 4; i++) ack(8'h02, "R1 drain");
    chk("R4 empty mark", cq_head, 8'h80);
    ack(8'h02, "R6 pop empty");
    step(0, 0, 0, 0, 0, 0, 0, 8'hFF, "R7 causes");
    ack(8'hFF, "R5 ack all");
    chk("R5 sticky bits", status, 8'h2D);
    step(1, 1, 8'h01, 0, 0, 0, 0, 0, "R9 mask");
    chk("R9 irq on", irq, 1);
    step(1, 1, 8'h00, 0, 0, 0, 0, 0, "R9 unmask");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R8 enqueue");
    ack(8'h04, "R8 ack txempty");
    chk("R8 cleared while pending", status[2], 0);
    step(0, 0, 0, 1, 1, 6'd33, 0, 0, "R3 auto release");
    chk("R3 not queued", cq_head, 8'h80);
    chk("R8 set when drained", status[2], 1);
    done(6'd7, "R10 prep"); done(6'd8, "R10 prep");
    step(0, 0, 0, 0, 0, 0, 1, 0, "R10 prep pend");
    step(1, 2, 8'hE0, 0, 0, 0, 0, 0, "R10 cmd7");
    chk("R10 cmd7 empties", cq_head, 8'h80);
    done(6'd4, "R10 prep");
    step(1, 2, 8'h20, 0, 0, 0, 0, 0, "R10 other cmd ignored");
    chk("R10 cmd1 keeps", cq_head, 4);
    step(1, 2, 8'h40, 0, 0, 0, 0, 0, "R10 cmd2");
    idle("R4 idle");
    void'($urandom(32'd1234));
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      bit [7:0] d = 8'($urandom);
      bit [1:0] a = 2'($urandom_range(0, 2));
      if (a == 2 && $urandom_range(0, 7) != 0) d[7:5] = 3'd1;
      step(r < 30, a, d, $urandom_range(0, 2) != 0, $urandom_range(0, 4) == 0,
           6'($urandom), $urandom_range(0, 2) == 0,
           ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'h00, "R7 random");
    end
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule